// File: doc/BRIEF.md
# Programmable Panel Timing Generator

This block produces the horizontal sync, vertical sync, data-enable and end-of-frame signals that drive a parallel RGB panel. Two counters track the position in the raster: a pixel counter that runs every clock while the block is running, and a line counter that moves on by one each time the pixel counter completes a line. Every compare window on an axis is measured from counter value 0, where the sync pulse starts. The visible area therefore begins only after the sync pulse and the back porch have passed.

Software programs the block through a 32-bit register port with byte addresses. It sets the sync pulse end, the visible window bounds and the period of each axis. It also sets an independent polarity for each of the three panel outputs, and a bit that selects the falling pixel-clock edge, which is passed out to the pixel-data path. A start bit sets the counters running. A stop bit is a graceful request: the block completes the current frame, then halts and raises a status flag. A frame-end status flag, cleared by writing 0, can be routed to an interrupt output.

Top module: `lcd_timing_gen`

## Requirements
- R1: While running, the pixel counter steps 0,1,…,HPERIOD-1 and wraps to 0. The horizontal sync is asserted (before polarity) while the pixel counter is below HSEND (register 0x0C bits [15:0]). The periods live in register 0x1C: HPERIOD in bits [31:16], VPERIOD in bits [15:0].
- R2: The line counter advances once per completed line and wraps after VPERIOD-1. The vertical sync is asserted while the line counter is below VSEND (register 0x10 bits [15:0]).
- R3: Data-enable is asserted only when HSTART ≤ pixel < HEND and VSTART ≤ line < VEND. Register 0x14 holds HSTART in [31:16] and HEND in [15:0]. Register 0x18 holds VSTART in [31:16] and VEND in [15:0].
- R4: In register 0x08, bit0 inverts hsync, bit1 inverts vsync and bit2 inverts data-enable (1 = active low). Bit3 is presented on `pclk_fall`.
- R5: `frame_end` is high for exactly the one cycle in which the counters are on the last pixel of the last line.
- R6: Status register 0x04 bit0 (frame flag) is set on the cycle after a frame ends. A status write clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R7: `irq` is high exactly when the frame flag is set and control bit2 (0x00) is 1.
- R8: Writing control bit1 while running does not stop the raster early: the block halts right after the next frame end and sets status bit1. While the request is pending, control bit0 reads 1 and bit1 reads 1.
- R9: Writing 0 to the status register clears every pending flag.
- R10: When not running, hsync, vsync and data-enable sit at their inactive levels and `frame_end` is 0. Writing control bit0 starts the raster at pixel 0, line 0 on the cycle after the write. A start write while already running has no effect on the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| hsync | output | 1 | Horizontal sync, programmed polarity |
| vsync | output | 1 | Vertical sync, programmed polarity |
| de | output | 1 | Data-enable, programmed polarity |
| pclk_fall | output | 1 | Selects the falling pixel-clock edge for data |
| frame_end | output | 1 | One-cycle pulse on the last pixel of a frame |
| irq | output | 1 | Frame-end interrupt |

## Verification
A pixel counter that slips or wraps early shows up within one line as an hsync or data-enable edge in the wrong cycle. A line counter that steps at the wrong moment misplaces vsync and data-enable within a frame, and it moves the frame-end pulse. The scoreboard compares all four outputs every cycle against a raster built from nested line and pixel loops, so the first wrong cycle is reported. A stop request mishandled in the control state appears as a halt that is not preceded by a frame-end pulse, or as a missing stopped flag. Flag bookkeeping errors appear at the status read and on `irq` within a cycle of the write.

// File: rtl/lcd_tg_pkg.sv
`timescale 1ns/1ps
package lcd_tg_pkg;

    localparam int REG_ADDR_W = 5;
    localparam int FIELD_W    = 16;

    typedef enum logic [2:0] {
        RG_CTRL  = 3'd0,
        RG_STAT  = 3'd1,
        RG_CFG   = 3'd2,
        RG_HSYNC = 3'd3,
        RG_VSYNC = 3'd4,
        RG_HWIN  = 3'd5,
        RG_VWIN  = 3'd6,
        RG_TOTAL = 3'd7
    } reg_idx_e;

    // bit0 = hs_low ... bit3 = pclk_fall
    typedef struct packed {
        logic pclk_fall;
        logic de_low;
        logic vs_low;
        logic hs_low;
    } pol_cfg_t;

    typedef struct packed {
        logic [FIELD_W-1:0] sync_end;
        logic [FIELD_W-1:0] win_start;
        logic [FIELD_W-1:0] win_end;
        logic [FIELD_W-1:0] period;
    } axis_cfg_t;

    function automatic logic in_span(input logic [31:0] v,
                                     input logic [31:0] lo,
                                     input logic [31:0] hi);
        return (v >= lo) && (v < hi);
    endfunction

endpackage

// File: rtl/lcd_tg_regs.sv
`timescale 1ns/1ps
module lcd_tg_regs
    import lcd_tg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [31:0]           rd_data,
    input  logic                  frame_end,
    output logic                  running,
    output logic                  irq_en,
    output logic                  eof_flag,
    output axis_cfg_t             hcfg,
    output axis_cfg_t             vcfg,
    output pol_cfg_t              pol
);

    logic     stop_pend;
    logic     stop_flag;
    logic     wr_hit;
    reg_idx_e wr_idx;
    reg_idx_e rd_idx;

    assign wr_hit = wr_en && (wr_addr[1:0] == 2'b00);
    assign wr_idx = reg_idx_e'(wr_addr[4:2]);
    assign rd_idx = reg_idx_e'(rd_addr[4:2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            stop_pend <= 1'b0;
            stop_flag <= 1'b0;
            eof_flag  <= 1'b0;
            irq_en    <= 1'b0;
            pol       <= '0;
            hcfg      <= '0;
            vcfg      <= '0;
        end else begin
            if (wr_hit) begin
                unique case (wr_idx)
                    RG_CTRL: begin
                        irq_en <= wr_data[2];
                        if (wr_data[1] && running)
                            stop_pend <= 1'b1;
                        else if (wr_data[0] && !running)
                            running <= 1'b1;
                    end
                    RG_STAT: begin
                        eof_flag  <= eof_flag  & wr_data[0];
                        stop_flag <= stop_flag & wr_data[1];
                    end
                    RG_CFG:   pol <= pol_cfg_t'(wr_data[3:0]);
                    RG_HSYNC: hcfg.sync_end <= wr_data[15:0];
                    RG_VSYNC: vcfg.sync_end <= wr_data[15:0];
                    RG_HWIN: begin
                        hcfg.win_start <= wr_data[31:16];
                        hcfg.win_end   <= wr_data[15:0];
                    end
                    RG_VWIN: begin
                        vcfg.win_start <= wr_data[31:16];
                        vcfg.win_end   <= wr_data[15:0];
                    end
                    RG_TOTAL: begin
                        hcfg.period <= wr_data[31:16];
                        vcfg.period <= wr_data[15:0];
                    end
                    default: ;
                endcase
            end
            // frame events take priority over a same-cycle write
            if (frame_end) begin
                eof_flag <= 1'b1;
                if (stop_pend) begin
                    running   <= 1'b0;
                    stop_pend <= 1'b0;
                    stop_flag <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_idx)
            RG_CTRL:  rd_data = {29'd0, irq_en, stop_pend, running};
            RG_STAT:  rd_data = {30'd0, stop_flag, eof_flag};
            RG_CFG:   rd_data = {28'd0, pol};
            RG_HSYNC: rd_data = {16'd0, hcfg.sync_end};
            RG_VSYNC: rd_data = {16'd0, vcfg.sync_end};
            RG_HWIN:  rd_data = {hcfg.win_start, hcfg.win_end};
            RG_VWIN:  rd_data = {vcfg.win_start, vcfg.win_end};
            RG_TOTAL: rd_data = {hcfg.period, vcfg.period};
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/lcd_tg_axis.sv
`timescale 1ns/1ps
module lcd_tg_axis
    import lcd_tg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step,
    input  axis_cfg_t        cfg,
    output logic [CNT_W-1:0] cnt,
    output logic             last,
    output logic             sync_on,
    output logic             win_on
);

    assign last    = (32'(cnt) + 32'd1) >= 32'(cfg.period);
    assign sync_on = 32'(cnt) < 32'(cfg.sync_end);
    assign win_on  = in_span(32'(cnt), 32'(cfg.win_start), 32'(cfg.win_end));

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (step)
            cnt <= last ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/lcd_tg_pins.sv
`timescale 1ns/1ps
module lcd_tg_pins
    import lcd_tg_pkg::*;
(
    input  logic     run,
    input  logic     hs_on,
    input  logic     vs_on,
    input  logic     de_on,
    input  pol_cfg_t pol,
    output logic     hsync,
    output logic     vsync,
    output logic     de,
    output logic     pclk_fall
);

    assign hsync     = (run & hs_on) ^ pol.hs_low;
    assign vsync     = (run & vs_on) ^ pol.vs_low;
    assign de        = (run & de_on) ^ pol.de_low;
    assign pclk_fall = pol.pclk_fall;

endmodule

// File: rtl/lcd_timing_gen.sv
`timescale 1ns/1ps
module lcd_timing_gen
    import lcd_tg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [31:0]           wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [31:0]           rd_data,
    output logic                  hsync,
    output logic                  vsync,
    output logic                  de,
    output logic                  pclk_fall,
    output logic                  frame_end,
    output logic                  irq
);

    localparam int N_AXIS = 2;   // 0 = pixels, 1 = lines

    logic      running;
    logic      irq_en;
    logic      eof_flag;
    axis_cfg_t hcfg;
    axis_cfg_t vcfg;
    pol_cfg_t  pol;

    axis_cfg_t        ax_cfg  [N_AXIS];
    logic             ax_step [N_AXIS];
    logic [CNT_W-1:0] ax_cnt  [N_AXIS];
    logic             ax_last [N_AXIS];
    logic             ax_sync [N_AXIS];
    logic             ax_win  [N_AXIS];

    logic [CNT_W-1:0] h_cnt;
    logic [CNT_W-1:0] v_cnt;
    logic             h_last;

    lcd_tg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .frame_end (frame_end),
        .running   (running),
        .irq_en    (irq_en),
        .eof_flag  (eof_flag),
        .hcfg      (hcfg),
        .vcfg      (vcfg),
        .pol       (pol)
    );

    assign ax_cfg[0]  = hcfg;
    assign ax_cfg[1]  = vcfg;
    assign ax_step[0] = 1'b1;
    assign ax_step[1] = ax_last[0];

    for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
        lcd_tg_axis #(.CNT_W(CNT_W)) u_axis (
            .clk     (clk),
            .rst     (rst),
            .run     (running),
            .step    (ax_step[a]),
            .cfg     (ax_cfg[a]),
            .cnt     (ax_cnt[a]),
            .last    (ax_last[a]),
            .sync_on (ax_sync[a]),
            .win_on  (ax_win[a])
        );
    end

    assign h_cnt     = ax_cnt[0];
    assign v_cnt     = ax_cnt[1];
    assign h_last    = ax_last[0];
    assign frame_end = running & ax_last[0] & ax_last[1];
    assign irq       = eof_flag & irq_en;

    lcd_tg_pins u_pins (
        .run       (running),
        .hs_on     (ax_sync[0]),
        .vs_on     (ax_sync[1]),
        .de_on     (ax_win[0] & ax_win[1]),
        .pol       (pol),
        .hsync     (hsync),
        .vsync     (vsync),
        .de        (de),
        .pclk_fall (pclk_fall)
    );

endmodule

// File: rtl/lcd_tg_checker.sv
`timescale 1ns/1ps
module lcd_tg_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             running,
    input logic [CNT_W-1:0] h_cnt,
    input logic [CNT_W-1:0] v_cnt,
    input logic             h_last,
    input logic             frame_end,
    input logic             eof_flag
);

    assert_pixel_step_R1: assert property (@(posedge clk) disable iff (rst)
        (running && !h_last) |=> (h_cnt == $past(h_cnt) + 1'b1));

    assert_line_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (running && !h_last) |=> $stable(v_cnt));

    assert_frame_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (h_cnt == '0 && v_cnt == '0));

    assert_eof_set_R6: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> eof_flag);

    assert_halt_on_frame_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> $past(frame_end));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !running |=> (h_cnt == '0 && v_cnt == '0));

endmodule

bind lcd_timing_gen lcd_tg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .running   (running),
    .h_cnt     (h_cnt),
    .v_cnt     (v_cnt),
    .h_last    (h_last),
    .frame_end (frame_end),
    .eof_flag  (eof_flag)
);

// File: tb/lcd_timing_gen_bench.sv
`timescale 1ns/1ps
module lcd_timing_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        hsync, vsync, de, pclk_fall, frame_end, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct packed {logic hs; logic vs; logic de; logic fe;} exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    lcd_timing_gen u_lcd_timing_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .hsync(hsync), .vsync(vsync), .de(de), .pclk_fall(pclk_fall),
        .frame_end(frame_end), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    // driver: expected raster from nested loops
    task automatic push_frames(input int n, input int ht, input int vt,
                               input int hse, input int vse,
                               input int hs0, input int he0,
                               input int vs0, input int ve0,
                               input logic [2:0] inv);
        for (int f = 0; f < n; f++)
            for (int v = 0; v < vt; v++)
                for (int h = 0; h < ht; h++) begin
                    exp_t e;
                    e.hs = (h < hse) ^ inv[0];
                    e.vs = (v < vse) ^ inv[1];
                    e.de = ((h >= hs0) && (h < he0) && (v >= vs0) && (v < ve0)) ^ inv[2];
                    e.fe = (h == ht - 1) && (v == vt - 1);
                    sb_q.push_back(e);
                end
    endtask

    // monitor
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check("R1 hsync", {31'd0, hsync}, {31'd0, e.hs});
            check("R2 vsync", {31'd0, vsync}, {31'd0, e.vs});
            check("R3 de", {31'd0, de}, {31'd0, e.de});
            check("R5 frame_end", {31'd0, frame_end}, {31'd0, e.fe});
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        last_fe;
        bit          seen;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // reset state (R10)
        check("R10 reset hsync", {31'd0, hsync}, 32'd0);
        check("R10 reset vsync", {31'd0, vsync}, 32'd0);
        check("R10 reset de", {31'd0, de}, 32'd0);
        check("R7 reset irq", {31'd0, irq}, 32'd0);
        rd(5'h04, d); check("R9 reset status", d, 32'd0);

        // geometry A
        wr(5'h0C, 32'd2);
        wr(5'h10, 32'd1);
        wr(5'h14, {16'd3, 16'd8});
        wr(5'h18, {16'd2, 16'd5});
        wr(5'h1C, {16'd10, 16'd6});
        wr(5'h04, 32'd0);
        wr(5'h00, 32'h1);
        push_frames(2, 10, 6, 2, 1, 3, 8, 2, 5, 3'b000);
        wait (sb_q.size() == 0);
        #0.5;
        rd(5'h04, d); check("R6 eof flag set", d & 32'h1, 32'h1);
        check("R7 irq masked", {31'd0, irq}, 32'd0);

        wr(5'h00, 32'h5);   // irq enable, start while running
        @(negedge clk);
        check("R7 irq raised", {31'd0, irq}, 32'd1);
        rd(5'h00, d); check("R10 start while running", d, 32'h5);
        wr(5'h04, 32'h2);   // clear frame flag
        @(negedge clk);
        rd(5'h04, d); check("R6 eof cleared", d, 32'd0);
        check("R7 irq dropped", {31'd0, irq}, 32'd0);

        // graceful stop
        wr(5'h00, 32'h6);
        @(negedge clk);
        rd(5'h00, d); check("R8 stop pending", d, 32'h7);
        last_fe = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            rd(5'h04, d);
            if (d[1]) begin seen = 1'b1; break; end
            last_fe = frame_end;
        end
        check("R8 stopped flag", {31'd0, seen}, 32'd1);
        check("R8 halted at frame end", {31'd0, last_fe}, 32'd1);
        check("R6 eof with stop", d, 32'h3);
        check("R7 irq on eof", {31'd0, irq}, 32'd1);
        check("R10 idle outputs", {28'd0, hsync, vsync, de, frame_end}, 32'd0);
        rd(5'h00, d); check("R8 control after stop", d, 32'h4);

        wr(5'h04, 32'h1);
        @(negedge clk);
        rd(5'h04, d); check("R6 write one keeps", d, 32'h1);
        wr(5'h04, 32'h0);
        @(negedge clk);
        rd(5'h04, d); check("R9 clear all", d, 32'd0);
        check("R7 irq after clear", {31'd0, irq}, 32'd0);

        // polarity and geometry B
        wr(5'h08, 32'hF);
        @(negedge clk);
        check("R4 idle inverted", {29'd0, hsync, vsync, de}, 32'h7);
        check("R4 pclk_fall", {31'd0, pclk_fall}, 32'd1);
        wr(5'h0C, 32'd3);
        wr(5'h10, 32'd2);
        wr(5'h14, {16'd2, 16'd7});
        wr(5'h18, {16'd1, 16'd3});
        wr(5'h1C, {16'd8, 16'd4});
        wr(5'h00, 32'h1);
        push_frames(2, 8, 4, 3, 2, 2, 7, 1, 3, 3'b111);
        wait (sb_q.size() == 0);
        #0.5;
        rd(5'h04, d); check("R6 eof after run B", d, 32'h1);
        check("R7 irq disabled", {31'd0, irq}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule